// File: doc/BRIEF.md
# Receive Stream Compare and Error-Halt Controller

This block sits behind a four-lane deserializer. It checks each received 32-bit word against a reference image held in an external synchronous RAM. A host raises `go` to arm it. The block then ignores the line until a word arrives in which no lane reports an idle character. From that word on it writes every received word, at consecutive addresses, to an external capture RAM. It also fetches the reference word at the same address and compares all bits of the two.

Two conditions can stop processing, each with its own enable. The first is a data difference. The second is an error indication on any lane. A one-shot mode fills the capture RAM exactly once and then stops with a completion flag. Three status words report to the host: per-lane link status, the address counter and the stop flags. In capture mode the first two words freeze when the block halts or is stopped. In live mode they keep following the line. The compare path is a fixed four stages deep, so the counter reads four past the offending word.

Top module: `rx_compare_halt`

## Requirements
- R1: After reset, `cap_we` is 0 and `stat_link`, `stat_count` and `stat_flags` are all 0.
- R2: A rising edge of `go` arms the block. While armed, words in which any `rx_idle` bit is 1 are not written. The first word with `rx_idle` = 0 is written to capture address 0.
- R3: Every accepted word appears on `cap_we`/`cap_addr`/`cap_wdata` one cycle after it is presented. Addresses rise by one per word and wrap modulo 2^ADDR_W. `ref_addr` equals `cap_addr`, and `ref_rdata` is expected one cycle later.
- R4: With `cfg_mismatch_stop` = 1, a word that differs from its reference word in any bit halts the block and sets `stat_flags` bit 8.
- R5: With `cfg_mismatch_stop` = 0, data differences never halt the block.
- R6: With `cfg_link_stop` = 1, a word whose `rx_err` has any bit set halts the block, whatever `cfg_mismatch_stop` is. With `cfg_link_stop` = 0, `rx_err` has no effect on halting.
- R7: The counter in `stat_count` advances by one each running cycle and is frozen from the halt onward. After a halt it equals the capture address of the offending word plus 4, modulo 2^ADDR_W.
- R8: With `cfg_one_shot` = 1, no word is written after address 2^ADDR_W−1. Four cycles later the block halts with `stat_flags` bits 8 and 11 set. If that last word also causes an enabled error halt, only bit 8 is set.
- R9: `stat_link` packs lane i into bits 4i..4i+3, as {0, kch, idle, err} with err in the lowest bit.
- R10: With `cfg_live_status` = 0, `stat_link` shows the status of the word most recently judged while running, and freezes on a halt or when `go` falls. With `cfg_live_status` = 1, it shows the lane inputs sampled at the previous clock edge.
- R11: A halted block stays halted while `go` stays high. When `go` is low at a clock edge, the next cycle has no write. Only a later rising edge of `go` re-arms the block, which clears the counter and the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| go | input | 1 | Run request; a rising edge arms, low stops |
| cfg_mismatch_stop | input | 1 | Halt on data difference |
| cfg_link_stop | input | 1 | Halt on lane error |
| cfg_one_shot | input | 1 | Stop after one fill of the capture RAM |
| cfg_live_status | input | 1 | 1: status follows the line; 0: status freezes |
| rx_data | input | 32 | Received word, four 8-bit lanes |
| rx_err | input | 4 | Per-lane error indication |
| rx_idle | input | 4 | Per-lane idle-character indication |
| rx_kch | input | 4 | Per-lane control-character indication |
| ref_addr | output | ADDR_W | Reference RAM read address |
| ref_rdata | input | 32 | Reference RAM data, one cycle after address |
| cap_we | output | 1 | Capture RAM write enable |
| cap_addr | output | ADDR_W | Capture RAM write address |
| cap_wdata | output | 32 | Capture RAM write data |
| stat_link | output | 16 | Packed per-lane link status |
| stat_count | output | 16 | Address counter, zero-extended |
| stat_flags | output | 16 | Bit 8 halted, bit 11 one-shot complete, others 0 |

## Verification
A one-shot fill ending and an error halt can be decided in the same cycle. The bench provokes this by corrupting the final word of a one-shot fill with mismatch stop enabled. It then expects the stop flag without the completion flag, at a counter of 3 in a 32-word space. A halt decision and a fall of `go` can also meet in one cycle. The reference model lets the stop win and flushes the words in flight. Every output is compared against that model on every clock.

// File: rtl/rx_compare_halt_pkg.sv
// Shared types for the receive compare controller.
// Assumes the status word is four bits per lane.
package rx_compare_halt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_RUN   = 2'd2,
        ST_HALT  = 2'd3
    } run_state_t;

    localparam int LANE_STAT_W = 4;

endpackage

// File: rtl/rx_compare_pipe.sv
// Word pipeline: accept register (drives capture and reference ports),
// alignment stage (waits for reference data), compare stage (decision).
// Assumes the reference RAM returns data one clock after ref_addr.
module rx_compare_pipe
    import rx_compare_halt_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 14,
    parameter int LANES  = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         go,
    input  logic                         acc,
    input  logic [ADDR_W-1:0]            acc_addr,
    input  logic                         acc_last,
    input  logic [DATA_W-1:0]            rx_data,
    input  logic [LANES-1:0]             rx_err,
    input  logic [LANES-1:0]             rx_idle,
    input  logic [LANES-1:0]             rx_kch,
    input  logic [DATA_W-1:0]            ref_rdata,
    output logic [ADDR_W-1:0]            ref_addr,
    output logic                         cap_we,
    output logic [ADDR_W-1:0]            cap_addr,
    output logic [DATA_W-1:0]            cap_wdata,
    output logic [LANES*LANE_STAT_W-1:0] cur_link,
    output logic                         dec_valid,
    output logic                         dec_mis,
    output logic                         dec_lerr,
    output logic                         dec_last,
    output logic [LANES*LANE_STAT_W-1:0] dec_link
);
    localparam int LINK_W = LANES * LANE_STAT_W;

    logic              s1_v, s1_last, s1_lerr;
    logic [ADDR_W-1:0] s1_addr;
    logic [DATA_W-1:0] s1_data;
    logic [LINK_W-1:0] s1_link;
    logic              s2_v, s2_last, s2_lerr;
    logic [DATA_W-1:0] s2_data;
    logic [LINK_W-1:0] s2_link;
    logic              s3_v, s3_mis, s3_last, s3_lerr;
    logic [LINK_W-1:0] s3_link;

    // Pack the lane indications into one nibble per lane.
    for (genvar i = 0; i < LANES; i++) begin : g_pack
        assign cur_link[i*LANE_STAT_W +: LANE_STAT_W] = {1'b0, rx_kch[i], rx_idle[i], rx_err[i]};
    end

    // Accept stage: register the incoming word with its address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_v <= 1'b0; s1_last <= 1'b0; s1_lerr <= 1'b0;
            s1_addr <= '0; s1_data <= '0; s1_link <= '0;
        end else begin
            s1_v    <= acc;
            s1_last <= acc_last;
            s1_lerr <= |rx_err;
            s1_addr <= acc_addr;
            s1_data <= rx_data;
            s1_link <= cur_link;
        end
    end

    // Alignment and compare stages; a low go flushes words in flight.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s2_v <= 1'b0; s2_last <= 1'b0; s2_lerr <= 1'b0; s2_data <= '0; s2_link <= '0;
            s3_v <= 1'b0; s3_mis <= 1'b0; s3_last <= 1'b0; s3_lerr <= 1'b0; s3_link <= '0;
        end else begin
            s2_v    <= s1_v & go;
            s2_last <= s1_last;
            s2_lerr <= s1_lerr;
            s2_data <= s1_data;
            s2_link <= s1_link;
            s3_v    <= s2_v & go;
            s3_mis  <= (s2_data != ref_rdata);
            s3_last <= s2_last;
            s3_lerr <= s2_lerr;
            s3_link <= s2_link;
        end
    end

    assign ref_addr  = s1_addr;
    assign cap_we    = s1_v;
    assign cap_addr  = s1_addr;
    assign cap_wdata = s1_data;
    assign dec_valid = s3_v;
    assign dec_mis   = s3_mis;
    assign dec_lerr  = s3_lerr;
    assign dec_last  = s3_last;
    assign dec_link  = s3_link;
endmodule

// File: rtl/rx_compare_ctrl.sv
// Run control: arming on a rising go, start on the first all-data word,
// address counter, halt decision and stop flags.
// Assumes the decision inputs come from a registered compare stage.
module rx_compare_ctrl
    import rx_compare_halt_pkg::*;
#(
    parameter int ADDR_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              all_data,
    input  logic              cfg_mismatch_stop,
    input  logic              cfg_link_stop,
    input  logic              cfg_one_shot,
    input  logic              dec_valid,
    input  logic              dec_mis,
    input  logic              dec_lerr,
    input  logic              dec_last,
    output logic              acc,
    output logic [ADDR_W-1:0] acc_addr,
    output logic              acc_last,
    output logic              running,
    output logic [ADDR_W-1:0] cnt,
    output logic              stop_flag,
    output logic              done_flag
);
    run_state_t state;
    logic       go_q, filled, err_hit, fin;

    // Accept decision and halt causes for the current cycle.
    always_comb begin
        acc      = go && ((state == ST_RUN && !(cfg_one_shot && filled)) ||
                          (state == ST_ARMED && all_data));
        acc_last = cfg_one_shot && (&cnt);
        err_hit  = dec_valid && ((dec_mis && cfg_mismatch_stop) || (dec_lerr && cfg_link_stop));
        fin      = dec_valid && dec_last;
    end

    // State, counter and flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE; go_q <= 1'b0; cnt <= '0;
            filled <= 1'b0; stop_flag <= 1'b0; done_flag <= 1'b0;
        end else begin
            go_q <= go;
            if (!go) begin
                state <= ST_IDLE;
            end else begin
                case (state)
                    ST_IDLE: if (!go_q) begin
                        state <= ST_ARMED; cnt <= '0; filled <= 1'b0;
                        stop_flag <= 1'b0; done_flag <= 1'b0;
                    end
                    ST_ARMED: if (all_data) begin
                        state <= ST_RUN; cnt <= cnt + 1'b1;
                        if (acc_last) filled <= 1'b1;
                    end
                    ST_RUN: begin
                        cnt <= cnt + 1'b1;
                        if (acc && acc_last) filled <= 1'b1;
                        if (err_hit || fin) begin
                            state     <= ST_HALT;
                            stop_flag <= 1'b1;
                            done_flag <= fin && !err_hit;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign acc_addr = cnt;
    assign running  = (state == ST_RUN);
endmodule

// File: rtl/rx_compare_status.sv
// Status words: live or frozen lane status, counter and flag word.
// Assumes ADDR_W is at most the status width.
module rx_compare_status
    import rx_compare_halt_pkg::*;
#(
    parameter int ADDR_W = 14,
    parameter int LANES  = 4,
    parameter int STAT_W = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         go,
    input  logic                         cfg_live_status,
    input  logic                         running,
    input  logic                         dec_valid,
    input  logic [LANES*LANE_STAT_W-1:0] dec_link,
    input  logic [LANES*LANE_STAT_W-1:0] cur_link,
    input  logic [ADDR_W-1:0]            cnt,
    input  logic                         stop_flag,
    input  logic                         done_flag,
    output logic [LANES*LANE_STAT_W-1:0] stat_link,
    output logic [STAT_W-1:0]            stat_count,
    output logic [STAT_W-1:0]            stat_flags
);
    localparam int LINK_W   = LANES * LANE_STAT_W;
    localparam int STOP_BIT = 8;
    localparam int DONE_BIT = 11;

    logic [LINK_W-1:0] live_q, held_q;

    // Live copy every cycle; held copy only while judging words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_q <= '0;
            held_q <= '0;
        end else begin
            live_q <= cur_link;
            if (go && running && dec_valid) held_q <= dec_link;
        end
    end

    // Output selection and flag word assembly.
    always_comb begin
        stat_link            = cfg_live_status ? live_q : held_q;
        stat_count           = STAT_W'(cnt);
        stat_flags           = '0;
        stat_flags[STOP_BIT] = stop_flag;
        stat_flags[DONE_BIT] = done_flag;
    end
endmodule

// File: rtl/rx_compare_halt.sv
// Top: receive compare and error-halt controller.
// Assumes external capture and reference RAMs with one-cycle read latency.
module rx_compare_halt
    import rx_compare_halt_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 14,
    parameter int LANES  = 4,
    parameter int STAT_W = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         go,
    input  logic                         cfg_mismatch_stop,
    input  logic                         cfg_link_stop,
    input  logic                         cfg_one_shot,
    input  logic                         cfg_live_status,
    input  logic [DATA_W-1:0]            rx_data,
    input  logic [LANES-1:0]             rx_err,
    input  logic [LANES-1:0]             rx_idle,
    input  logic [LANES-1:0]             rx_kch,
    output logic [ADDR_W-1:0]            ref_addr,
    input  logic [DATA_W-1:0]            ref_rdata,
    output logic                         cap_we,
    output logic [ADDR_W-1:0]            cap_addr,
    output logic [DATA_W-1:0]            cap_wdata,
    output logic [LANES*LANE_STAT_W-1:0] stat_link,
    output logic [STAT_W-1:0]            stat_count,
    output logic [STAT_W-1:0]            stat_flags
);
    localparam int LINK_W = LANES * LANE_STAT_W;

    logic              acc, acc_last, running, stop_flag, done_flag;
    logic [ADDR_W-1:0] acc_addr, cnt;
    logic              dec_valid, dec_mis, dec_lerr, dec_last;
    logic [LINK_W-1:0] dec_link, cur_link;

    rx_compare_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .go(go), .all_data(rx_idle == '0),
        .cfg_mismatch_stop(cfg_mismatch_stop), .cfg_link_stop(cfg_link_stop),
        .cfg_one_shot(cfg_one_shot), .dec_valid(dec_valid), .dec_mis(dec_mis),
        .dec_lerr(dec_lerr), .dec_last(dec_last), .acc(acc), .acc_addr(acc_addr),
        .acc_last(acc_last), .running(running), .cnt(cnt),
        .stop_flag(stop_flag), .done_flag(done_flag)
    );

    rx_compare_pipe #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .LANES(LANES)) u_pipe (
        .clk(clk), .rst_n(rst_n), .go(go), .acc(acc), .acc_addr(acc_addr),
        .acc_last(acc_last), .rx_data(rx_data), .rx_err(rx_err), .rx_idle(rx_idle),
        .rx_kch(rx_kch), .ref_rdata(ref_rdata), .ref_addr(ref_addr), .cap_we(cap_we),
        .cap_addr(cap_addr), .cap_wdata(cap_wdata), .cur_link(cur_link),
        .dec_valid(dec_valid), .dec_mis(dec_mis), .dec_lerr(dec_lerr),
        .dec_last(dec_last), .dec_link(dec_link)
    );

    rx_compare_status #(.ADDR_W(ADDR_W), .LANES(LANES), .STAT_W(STAT_W)) u_stat (
        .clk(clk), .rst_n(rst_n), .go(go), .cfg_live_status(cfg_live_status),
        .running(running), .dec_valid(dec_valid), .dec_link(dec_link),
        .cur_link(cur_link), .cnt(cnt), .stop_flag(stop_flag), .done_flag(done_flag),
        .stat_link(stat_link), .stat_count(stat_count), .stat_flags(stat_flags)
    );
endmodule

// File: rtl/rx_compare_halt_chk.sv
// Checker for rx_compare_halt, attached by bind below.
// Assumes the top's default status layout (bit 8 halted, bit 11 done).
module rx_compare_halt_chk #(
    parameter int ADDR_W = 14,
    parameter int LINK_W = 16,
    parameter int STAT_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              go,
    input logic              cfg_live_status,
    input logic              cap_we,
    input logic [ADDR_W-1:0] cap_addr,
    input logic [LINK_W-1:0] stat_link,
    input logic [STAT_W-1:0] stat_count,
    input logic [STAT_W-1:0] stat_flags
);
    // Back-to-back writes use consecutive, wrapping addresses.
    assert_addr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cap_we && $past(cap_we) |-> cap_addr == ADDR_W'($past(cap_addr) + 1'b1));

    // Completion flag never appears without the stop flag.
    assert_done_implies_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        stat_flags[11] |-> stat_flags[8]);

    // A low go at an edge leaves no write in the following cycle.
    assert_stop_blocks_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !go |=> !cap_we);

    // A halted block with go held high keeps its counter and flag.
    assert_halt_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        stat_flags[8] && go && $past(go) |=> $stable(stat_count) && stat_flags[8]);

    // Frozen lane status does not move while halted in capture mode.
    assert_link_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        stat_flags[8] && go && $past(go) && !cfg_live_status |=> cfg_live_status || $stable(stat_link));
endmodule

bind rx_compare_halt rx_compare_halt_chk #(
    .ADDR_W(ADDR_W), .LINK_W(LANES*4), .STAT_W(STAT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .go(go), .cfg_live_status(cfg_live_status),
    .cap_we(cap_we), .cap_addr(cap_addr), .stat_link(stat_link),
    .stat_count(stat_count), .stat_flags(stat_flags)
);

// File: tb/rx_compare_halt_test.sv
module rx_compare_halt_test;
    localparam int CLK_PERIOD = 10;
    localparam int AW    = 5;
    localparam int DEPTH = 1 << AW;

    logic        clk = 1'b0, rst_n = 1'b0, go = 1'b0;
    logic        cfg_mis = 1'b1, cfg_link = 1'b1, cfg_one = 1'b0, cfg_live = 1'b0;
    logic [31:0] rx_data = '0;
    logic [3:0]  rx_err = '0, rx_idle = 4'hF, rx_kch = '0;
    logic [AW-1:0] ref_addr, cap_addr;
    logic [31:0] ref_rdata = '0, cap_wdata;
    logic        cap_we;
    logic [15:0] stat_link, stat_count, stat_flags;

    int n_chk = 0, n_fail = 0, cycles = 0;

    rx_compare_halt #(.ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .go(go), .cfg_mismatch_stop(cfg_mis),
        .cfg_link_stop(cfg_link), .cfg_one_shot(cfg_one), .cfg_live_status(cfg_live),
        .rx_data(rx_data), .rx_err(rx_err), .rx_idle(rx_idle), .rx_kch(rx_kch),
        .ref_addr(ref_addr), .ref_rdata(ref_rdata), .cap_we(cap_we), .cap_addr(cap_addr),
        .cap_wdata(cap_wdata), .stat_link(stat_link), .stat_count(stat_count),
        .stat_flags(stat_flags)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] refw(input int i);
        logic [7:0] b = 8'(i);
        return {b, ~b, 8'h5A, b ^ 8'hC3};
    endfunction

    function automatic logic [15:0] pack(input logic [3:0] e, input logic [3:0] d, input logic [3:0] k);
        logic [15:0] r = '0;
        for (int i = 0; i < 4; i++) r[4*i +: 4] = {1'b0, k[i], d[i], e[i]};
        return r;
    endfunction

    // Reference RAM with one-cycle read latency.
    always @(posedge clk) ref_rdata <= refw(int'(ref_addr));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    typedef struct { int addr; logic [31:0] data; bit lerr; logic [15:0] link; bit last; int age; } ent_t;
    ent_t q[$];
    int   m_state = 0, m_cnt = 0;   // 0 idle, 1 armed, 2 running, 3 halted
    bit   m_goq = 0, m_filled = 0, m_stop = 0, m_done = 0, m_we = 0;
    int   m_addr = 0;
    logic [31:0] m_data = '0;
    logic [15:0] m_live = '0, m_held = '0;

    always @(posedge clk) begin
        bit acc, have;
        ent_t d, n;
        acc = 0; have = 0;
        foreach (q[i]) q[i].age++;
        if (!rst_n) begin
            q.delete(); m_state = 0; m_cnt = 0; m_goq = 0; m_filled = 0;
            m_stop = 0; m_done = 0; m_we = 0; m_live = '0; m_held = '0;
        end else begin
            if (q.size() > 0 && q[0].age == 3) begin d = q[0]; have = 1; end
            while (q.size() > 0 && q[0].age >= 3) void'(q.pop_front());
            m_live = pack(rx_err, rx_idle, rx_kch);
            n.addr = m_cnt; n.data = rx_data; n.lerr = |rx_err;
            n.link = m_live; n.last = cfg_one && (m_cnt == DEPTH-1); n.age = 0;
            if (!go) begin
                q.delete(); m_state = 0;
            end else if (m_state == 0) begin
                if (!m_goq) begin m_state = 1; m_cnt = 0; m_filled = 0; m_stop = 0; m_done = 0; end
            end else if (m_state == 1) begin
                if (rx_idle == 0) begin
                    acc = 1; m_state = 2; m_cnt++;
                    if (n.last) m_filled = 1;
                end
            end else if (m_state == 2) begin
                bit eh;
                acc = !(cfg_one && m_filled);
                if (acc && n.last) m_filled = 1;
                m_cnt = (m_cnt + 1) % DEPTH;
                if (have) begin
                    m_held = d.link;
                    eh = (cfg_mis && d.data != refw(d.addr)) || (cfg_link && d.lerr);
                    if (eh || d.last) begin m_state = 3; m_stop = 1; m_done = d.last && !eh; end
                end
            end
            m_goq = go;
            if (acc) q.push_back(n);
        end
        m_we = acc; m_addr = n.addr; m_data = n.data;
        #1;
        chk("R3 cap_we", 32'(cap_we), 32'(m_we));
        if (m_we) begin
            chk("R3 cap_addr", 32'(cap_addr), 32'(m_addr));
            chk("R3 ref_addr", 32'(ref_addr), 32'(m_addr));
            chk("R3 cap_wdata", cap_wdata, m_data);
        end
        chk("R7 stat_count", 32'(stat_count), 32'(m_cnt));
        chk("R4 stat_flags", 32'(stat_flags), 32'({m_done, 2'b00, m_stop, 8'h00}));
        chk("R9 stat_link", 32'(stat_link), 32'(cfg_live ? m_live : m_held));
    end

    // ---------------- stimulus ----------------
    task automatic cyc(input logic [31:0] dt, input logic [3:0] idl, input logic [3:0] er, input logic [3:0] kc);
        rx_data = dt; rx_idle = idl; rx_err = er; rx_kch = kc;
        @(negedge clk);
    endtask

    task automatic set_go(input logic v);
        go = v; rx_idle = 4'hF; rx_err = '0;
        @(negedge clk);
    endtask

    // n words from address 0; word bad gets a flipped bit, word ew an error on lane el.
    task automatic stream(input int n, input int bad, input int ew, input int el);
        for (int k = 0; k < n; k++) begin
            logic [3:0] e = '0;
            if (k == ew) e[el] = 1'b1;
            cyc(refw(k % DEPTH) ^ ((k == bad) ? 32'h0000_0100 : 32'h0), 4'h0, e, 4'h0);
        end
        for (int k = 0; k < 6; k++) cyc('0, 4'hF, 4'h0, 4'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 cap_we", 32'(cap_we), 0);
        chk("R1 status", {stat_link, stat_count}, 0);
        chk("R1 flags", 32'(stat_flags), 0);
        rst_n = 1'b1;

        // Arm, idles ignored, first data word at address 0; mismatch at word 10.
        set_go(1);
        for (int k = 0; k < 3; k++) begin
            cyc(32'hDEAD_BEEF, 4'b0010, 4'h0, 4'h0);
            chk("R2 idle not written", 32'(cap_we), 0);
        end
        cyc(refw(0), 4'h0, 4'h0, 4'h0);
        chk("R2 first word address", {31'(cap_addr), cap_we}, 1);
        for (int k = 1; k < 14; k++) cyc(refw(k) ^ ((k == 10) ? 32'h8000_0000 : 0), 4'h0, 4'h0, 4'h0);
        repeat (4) cyc('0, 4'hF, 4'h0, 4'h0);
        chk("R4 mismatch halt", 32'(stat_flags), 32'h100);
        chk("R7 count offset", 32'(stat_count), 14);
        // Still halted with go high.
        repeat (10) cyc(refw(3), 4'h0, 4'h0, 4'h0);
        chk("R11 held count", 32'(stat_count), 14);
        chk("R11 no writes", 32'(cap_we), 0);
        set_go(0);
        chk("R11 flag kept when stopped", 32'(stat_flags), 32'h100);
        set_go(1);
        chk("R11 rearm clears", {stat_flags, stat_count}, 0);

        // Mismatch stop off: difference at 3 ignored, lane C error at 6 halts.
        cfg_mis = 1'b0;
        stream(12, 3, 6, 2);
        chk("R5 R6 link halt", 32'(stat_flags), 32'h100);
        chk("R7 link count", 32'(stat_count), 10);
        chk("R10 frozen lane status", 32'(stat_link), 32'h0100);
        set_go(0); set_go(1);

        // Both stops off: errors and differences ignored across a wrap.
        cfg_link = 1'b0;
        stream(40, 5, 7, 0);
        chk("R6 link error ignored", 32'(stat_flags), 0);
        cfg_live = 1'b1;
        cyc(32'h1234_5678, 4'h0, 4'b0001, 4'b1010);
        chk("R10 live lane status", 32'(stat_link), 32'h4041);
        cfg_live = 1'b0;
        set_go(0);
        chk("R11 stop ends writes", 32'(cap_we), 0);
        set_go(1);

        // One-shot fill, clean.
        cfg_one = 1'b1; cfg_mis = 1'b1; cfg_link = 1'b1;
        stream(36, -1, -1, 0);
        chk("R8 one-shot flags", 32'(stat_flags), 32'h900);
        chk("R8 one-shot count", 32'(stat_count), 3);
        set_go(0); set_go(1);

        // One-shot with corrupted last word: error wins the same cycle.
        stream(36, DEPTH-1, -1, 0);
        chk("R8 last word error", 32'(stat_flags), 32'h100);
        chk("R8 last word count", 32'(stat_count), 3);
        set_go(0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected<20000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule